// File: doc/BRIEF.md
# Wide-to-Narrow Bus-Matching Read Port

This block takes 36-bit entries from a FIFO and hands them to a narrow read port one piece at a time. In word mode each entry becomes two 18-bit reads. In byte mode each entry becomes four 9-bit reads, placed in the low bits of the 18-bit output. An endian setting picks whether the most significant or the least significant piece of the entry goes out first.

The upstream side is a pop handshake. The FIFO shows a valid flag and its front entry, and the block raises a pop strobe in the same cycle that it takes the entry into its holding register. The downstream side has a read enable, an active-low chip select, a registered 18-bit data output with an output-enable indication, and an empty status.

Width and endian order are sampled while master reset is low and on the first clock edge after it is released. They stay fixed after that. A partial reset flushes the entry being unpacked and clears the output register, but it keeps the sampled configuration.

Top module: `narrow_rd_port`

## Requirements
- R1: While `rst_ni` is low, `empty_o` is 1 and the output register is zero. `size_byte_i` and `big_end_i` are sampled during master reset and on the first rising edge after its release. Later changes to these inputs have no effect on the read order or the width.
- R2: `fifo_pop_o` is high only when `fifo_valid_i` is high, `prst_ni` is high, and either no entry is held or the read in this cycle takes the last piece of the held entry.
- R3: In word mode (`size_byte_i` = 0 at reset), one entry gives two 18-bit reads: bits [35:18] and bits [17:0].
- R4: In byte mode (`size_byte_i` = 1 at reset), one entry gives four 9-bit reads: [35:27], [26:18], [17:9] and [8:0]. Output bits [17:9] are zero during these reads.
- R5: With `big_end_i` = 1 at reset, the most significant piece is read first, and the order runs downward from there.
- R6: With `big_end_i` = 0 at reset, the least significant piece is read first, and the order runs upward from there.
- R7: A read happens on a rising edge only when `rd_en_i` = 1, `cs_ni` = 0 and an entry is held. In every other cycle the output register and the read position keep their values.
- R8: While `cs_ni` is 1, `data_oe_o` is 0 and `data_o` is driven to zero. While `cs_ni` is 0, `data_oe_o` is 1 and `data_o` shows the output register.
- R9: When `prst_ni` is low at a rising edge, the held entry is discarded, `empty_o` becomes 1 and the output register is cleared. The sampled width and endian settings are kept.
- R10: `empty_o` stays 0 while pieces of the held entry remain to be read, even if `fifo_valid_i` is 0. It becomes 1 after the last piece is read, unless a new entry is popped at that same edge.
- R11: The piece taken at a read edge appears on `data_o` right after that edge and stays there until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous active-low master reset; configuration sampled while low |
| prst_ni | input | 1 | Synchronous active-low partial reset |
| size_byte_i | input | 1 | 1 selects byte mode, 0 selects word mode (sampled at reset) |
| big_end_i | input | 1 | 1 sends the most significant piece first (sampled at reset) |
| fifo_valid_i | input | 1 | FIFO holds an entry |
| fifo_data_i | input | 36 | FIFO front entry |
| fifo_pop_o | output | 1 | Takes the front entry at this edge |
| rd_en_i | input | 1 | Read enable, active high |
| cs_ni | input | 1 | Chip select, active low |
| data_o | output | 18 | Narrow read data |
| data_oe_o | output | 1 | Output driven |
| empty_o | output | 1 | No piece available to read |

## Verification
The bench goes after the edge where the last piece is read while the FIFO already holds the next entry. A design that refills one cycle late shows a false empty in that cycle, and one that refills early overwrites a piece that has not been read yet. The bench also flips the size and endian inputs after reset and pulses partial reset in the middle of an entry. A design that tracks these inputs live, or that clears its configuration on a flush, reads pieces in the wrong order or at the wrong width. Reads attempted with chip select high, and reads attempted while nothing is held, must leave both the data and the position unchanged. Byte-mode reads must show zero padding in the upper bits.

// File: rtl/narrow_rd_pkg.sv
package narrow_rd_pkg;
  parameter int unsigned DEF_WIDE_W   = 36;
  parameter int unsigned DEF_NARROW_W = 18;
  parameter int unsigned DEF_BYTE_W   = 9;

  typedef struct packed {
    logic byte_mode;
    logic big_end;
  } rd_cfg_t;
endpackage

// File: rtl/nr_cfg_latch.sv
module nr_cfg_latch
  import narrow_rd_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    size_byte_i,
  input  logic    big_end_i,
  output rd_cfg_t cfg_o
);
  logic arm_q;

  // armed during reset and for the first edge after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b1;
    else         arm_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (arm_q) cfg_o <= '{byte_mode: size_byte_i, big_end: big_end_i};
  end
endmodule

// File: rtl/nr_slice_pick.sv
module nr_slice_pick
  import narrow_rd_pkg::*;
#(
  parameter  int unsigned WIDE_W   = DEF_WIDE_W,
  parameter  int unsigned NARROW_W = DEF_NARROW_W,
  parameter  int unsigned BYTE_W   = DEF_BYTE_W,
  localparam int unsigned WORDS    = WIDE_W / NARROW_W,
  localparam int unsigned LANES    = WIDE_W / BYTE_W,
  localparam int unsigned IDX_W    = $clog2(LANES),
  localparam int unsigned WSEL_W   = $clog2(WORDS)
) (
  input  logic [WIDE_W-1:0]   word_i,
  input  rd_cfg_t             cfg_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [NARROW_W-1:0] slice_o
);
  logic [NARROW_W-1:0] word_sl [WORDS];
  logic [NARROW_W-1:0] byte_sl [LANES];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign word_sl[w] = word_i[w*NARROW_W +: NARROW_W];
  end

  for (genvar b = 0; b < LANES; b++) begin : g_byte
    assign byte_sl[b] = {{(NARROW_W-BYTE_W){1'b0}}, word_i[b*BYTE_W +: BYTE_W]};
  end

  logic [IDX_W-1:0]  lane_sel;
  logic [WSEL_W-1:0] word_sel;

  always_comb begin
    lane_sel = cfg_i.big_end ? IDX_W'(LANES-1) - idx_i : idx_i;
    word_sel = cfg_i.big_end ? WSEL_W'(WORDS-1) - idx_i[WSEL_W-1:0] : idx_i[WSEL_W-1:0];
    slice_o  = cfg_i.byte_mode ? byte_sl[lane_sel] : word_sl[word_sel];
  end
endmodule

// File: rtl/nr_unpack_seq.sv
module nr_unpack_seq
  import narrow_rd_pkg::*;
#(
  parameter  int unsigned WIDE_W   = DEF_WIDE_W,
  parameter  int unsigned NARROW_W = DEF_NARROW_W,
  parameter  int unsigned BYTE_W   = DEF_BYTE_W,
  localparam int unsigned WORDS    = WIDE_W / NARROW_W,
  localparam int unsigned LANES    = WIDE_W / BYTE_W,
  localparam int unsigned IDX_W    = $clog2(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prst_ni,
  input  logic                rd_en_i,
  input  logic                cs_ni,
  input  rd_cfg_t             cfg_i,
  input  logic                fifo_valid_i,
  input  logic [WIDE_W-1:0]   fifo_data_i,
  input  logic [NARROW_W-1:0] slice_i,
  output logic                fifo_pop_o,
  output logic [WIDE_W-1:0]   word_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic                loaded_o,
  output logic [NARROW_W-1:0] out_o
);
  logic read_ok, last_sl;

  assign read_ok    = rd_en_i & ~cs_ni & loaded_o;
  assign last_sl    = idx_o == (cfg_i.byte_mode ? IDX_W'(LANES-1) : IDX_W'(WORDS-1));
  assign fifo_pop_o = fifo_valid_i & prst_ni & (~loaded_o | (read_ok & last_sl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o   <= '0;
      idx_o    <= '0;
      loaded_o <= 1'b0;
      out_o    <= '0;
    end else if (!prst_ni) begin
      word_o   <= '0;
      idx_o    <= '0;
      loaded_o <= 1'b0;
      out_o    <= '0;
    end else begin
      if (read_ok) begin
        out_o <= slice_i;
        idx_o <= last_sl ? '0 : idx_o + 1'b1;
        if (last_sl) loaded_o <= 1'b0;
      end
      // refill overrides the drain of the last piece
      if (fifo_pop_o) begin
        word_o   <= fifo_data_i;
        idx_o    <= '0;
        loaded_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/narrow_rd_port.sv
module narrow_rd_port
  import narrow_rd_pkg::*;
#(
  parameter  int unsigned WIDE_W   = DEF_WIDE_W,
  parameter  int unsigned NARROW_W = DEF_NARROW_W,
  parameter  int unsigned BYTE_W   = DEF_BYTE_W,
  localparam int unsigned LANES    = WIDE_W / BYTE_W,
  localparam int unsigned IDX_W    = $clog2(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prst_ni,
  input  logic                size_byte_i,
  input  logic                big_end_i,
  input  logic                fifo_valid_i,
  input  logic [WIDE_W-1:0]   fifo_data_i,
  output logic                fifo_pop_o,
  input  logic                rd_en_i,
  input  logic                cs_ni,
  output logic [NARROW_W-1:0] data_o,
  output logic                data_oe_o,
  output logic                empty_o
);
  rd_cfg_t             cfg;
  logic [WIDE_W-1:0]   word_q;
  logic [IDX_W-1:0]    idx_q;
  logic                loaded_q;
  logic [NARROW_W-1:0] slice;
  logic [NARROW_W-1:0] out_q;

  nr_cfg_latch u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .size_byte_i (size_byte_i),
    .big_end_i   (big_end_i),
    .cfg_o       (cfg)
  );

  nr_slice_pick #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W)) u_pick (
    .word_i  (word_q),
    .cfg_i   (cfg),
    .idx_i   (idx_q),
    .slice_o (slice)
  );

  nr_unpack_seq #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prst_ni      (prst_ni),
    .rd_en_i      (rd_en_i),
    .cs_ni        (cs_ni),
    .cfg_i        (cfg),
    .fifo_valid_i (fifo_valid_i),
    .fifo_data_i  (fifo_data_i),
    .slice_i      (slice),
    .fifo_pop_o   (fifo_pop_o),
    .word_o       (word_q),
    .idx_o        (idx_q),
    .loaded_o     (loaded_q),
    .out_o        (out_q)
  );

  assign data_o    = cs_ni ? '0 : out_q;
  assign data_oe_o = ~cs_ni;
  assign empty_o   = ~loaded_q;
endmodule

// File: rtl/narrow_rd_port_chk.sv
module narrow_rd_port_chk
  import narrow_rd_pkg::*;
#(
  parameter int unsigned NARROW_W = DEF_NARROW_W,
  parameter int unsigned BYTE_W   = DEF_BYTE_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                prst_ni,
  input logic                rd_en_i,
  input logic                cs_ni,
  input logic                fifo_valid_i,
  input logic                fifo_pop_o,
  input logic                empty_o,
  input logic                data_oe_o,
  input logic [NARROW_W-1:0] data_o,
  input logic [NARROW_W-1:0] out_q,
  input rd_cfg_t             cfg
);
  p_pop_needs_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> fifo_valid_i);

  p_no_pop_while_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && (!rd_en_i || cs_ni)) |-> !fifo_pop_o);

  p_refill_not_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !empty_o);

  p_byte_pad_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.byte_mode |-> (out_q[NARROW_W-1:BYTE_W] == '0));

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prst_ni && (!rd_en_i || cs_ni)) |=> $stable(out_q));

  p_disabled_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (data_o == '0 && !data_oe_o));

  p_flush_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prst_ni |=> (empty_o && out_q == '0));
endmodule

bind narrow_rd_port narrow_rd_port_chk #(.NARROW_W(NARROW_W), .BYTE_W(BYTE_W)) u_chk (
  .out_q (out_q),
  .cfg   (cfg),
  .*
);

// File: tb/narrow_rd_port_test.sv
module narrow_rd_port_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prst_ni = 1'b1;
  logic        size_byte_i = 1'b0;
  logic        big_end_i = 1'b0;
  logic        fifo_valid_i = 1'b0;
  logic [35:0] fifo_data_i = '0;
  logic        fifo_pop_o;
  logic        rd_en_i = 1'b0;
  logic        cs_ni = 1'b1;
  logic [17:0] data_o;
  logic        data_oe_o;
  logic        empty_o;

  narrow_rd_port uut (.*);

  always #10 clk_i = ~clk_i;

  int unsigned n_chk = 0, n_bad = 0;
  logic [35:0] fifo_q[$];
  logic [17:0] sq[$];
  int          hold = 0;
  logic [17:0] exp_data = '0;
  bit          cfg_b, cfg_g;

  function automatic logic [17:0] exp_slice(logic [35:0] w, bit byt, bit big, int k);
    int n = byt ? 4 : 2;
    int p = big ? n - 1 - k : k;
    if (byt) return {9'b0, w[p*9 +: 9]};
    return w[p*18 +: 18];
  endfunction

  task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(logic [35:0] w);
    int n = cfg_b ? 4 : 2;
    fifo_q.push_back(w);
    for (int k = 0; k < n; k++) sq.push_back(exp_slice(w, cfg_b, cfg_g, k));
  endtask

  // one cycle: drive after negedge, check pop, model the edge, check outputs
  task automatic step(bit rd, bit cs, bit prst);
    bit    exp_pop, rdok;
    string tag;
    rd_en_i = rd; cs_ni = cs; prst_ni = prst;
    fifo_valid_i = fifo_q.size() > 0;
    fifo_data_i  = fifo_valid_i ? fifo_q[0] : {4'($urandom), $urandom};
    #5;
    exp_pop = fifo_valid_i && prst && (hold == 0 || (rd && !cs && hold == 1));
    chk(fifo_pop_o == exp_pop, "R2 pop", 36'(fifo_pop_o), 36'(exp_pop));
    @(posedge clk_i);
    rdok = rd && !cs && hold > 0 && prst;
    if (!prst) begin
      repeat (hold) void'(sq.pop_front());
      hold = 0; exp_data = '0;
      tag = "R9 flush";
    end else begin
      if (rdok) begin exp_data = sq.pop_front(); hold--; end
      if (exp_pop) begin void'(fifo_q.pop_front()); hold = cfg_b ? 4 : 2; end
      tag = {cfg_b ? "R4" : "R3", cfg_g ? " R5" : " R6", rdok ? " R11" : " R7"};
    end
    @(negedge clk_i);
    chk(empty_o == (hold == 0), "R10 empty", 36'(empty_o), 36'(hold == 0));
    chk(data_o == (cs ? 18'h0 : exp_data), tag, 36'(data_o), 36'(cs ? 18'h0 : exp_data));
    chk(data_oe_o == !cs, "R8 oe", 36'(data_oe_o), 36'(!cs));
  endtask

  task automatic mreset(bit byt, bit big);
    rst_ni = 1'b0; size_byte_i = byt; big_end_i = big;
    rd_en_i = 1'b0; cs_ni = 1'b0; prst_ni = 1'b1; fifo_valid_i = 1'b0;
    fifo_q.delete(); sq.delete();
    repeat (4) @(negedge clk_i);
    chk(empty_o == 1'b1, "R1 empty in reset", 36'(empty_o), 36'd1);
    chk(data_o == 18'h0, "R1 data in reset", 36'(data_o), 36'd0);
    rst_ni = 1'b1;
    hold = 0; exp_data = '0; cfg_b = byt; cfg_g = big;
    step(1'b0, 1'b0, 1'b1);
    // inputs flipped: must have no effect (R1)
    size_byte_i = !byt; big_end_i = !big;
  endtask

  task automatic run_random(int cycles);
    for (int c = 0; c < cycles; c++) begin
      bit rd   = ($urandom % 4) != 0;
      bit cs   = ($urandom % 6) == 0;
      bit prst = ($urandom % 150) != 0;
      step(rd, cs, prst);
      if (fifo_q.size() < 6 && ($urandom % 3) == 0) push({4'($urandom), $urandom});
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk_i);
    for (int m = 0; m < 4; m++) begin
      mreset(m[0], m[1]);
      // directed: one entry, FIFO then empty; empty_o stays low across pieces (R10)
      push(36'hA_BCDE_F123);
      step(1'b0, 1'b0, 1'b1);
      for (int k = 0; k < (cfg_b ? 4 : 2); k++) step(1'b1, 1'b0, 1'b1);
      chk(empty_o == 1'b1, "R10 drained", 36'(empty_o), 36'd1);
      // directed: back-to-back entries, refill at the last-piece edge (R2)
      push(36'h1_2345_6789); push(36'hF_EDCB_A987);
      for (int k = 0; k < 9; k++) step(1'b1, 1'b0, 1'b1);
      // directed: read with chip select high is ignored (R7, R8)
      push(36'h0_FF00_FF00);
      step(1'b0, 1'b0, 1'b1);
      step(1'b1, 1'b1, 1'b1);
      step(1'b1, 1'b0, 1'b1);
      // directed: flush mid-entry keeps configuration (R9)
      step(1'b0, 1'b0, 1'b0);
      push(36'h9_8765_4321);
      for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b1);
      run_random(2500);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule